// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of 64-bit scatter-gather descriptors held in system memory. Once started with a base address and an expected byte count, it fetches one descriptor at a time through a simple read request/response port. It decodes the two-bit action field and the flag bits of each descriptor. Transfer entries go to an external data mover as address/length commands, link entries redirect the walk, and no-op or reserved-action entries are stepped over.

A descriptor places its buffer address in bits 63:32 and its byte length in bits 31:16. Bits 15:6 must be zero. The low attribute byte holds the flags. The walk ends at the entry that carries the end flag, or earlier on a malformed entry. At the end, the block pulses a completion strobe and leaves two sticky error flags plus a small error-state code for the host to read. A descriptor may also request a one-cycle interrupt pulse once the data mover reports its transfer finished.

Top module: `desc_chain_walker`

## Requirements
- R1: While reset is asserted and immediately after it is released, busy_o, rd_req_o, cmd_valid_o, done_o, irq_o, err_desc_o and err_len_o are 0 and err_state_o is 2'b00.
- R2: A start_i sampled while idle makes the first fetch at base_addr_i. After any entry that is neither a link nor terminal, the next fetch is at the current address plus 8. A pending fetch keeps rd_req_o and rd_addr_o stable until rd_ready_i.
- R3: An entry with attribute bit 0 (valid) set, bit 5 set and bit 4 clear (action 2'b10) produces one command. Its cmd_addr_o is bits 63:32, and its cmd_len_o is bits 31:16, where a field of 0 stands for 65536. The command holds stable until cmd_ready_i.
- R4: Entries with action 2'b00 (no-op) or 2'b01 (reserved) issue no command and are stepped over. If such an entry has attribute bit 1 (end) set, the walk finishes cleanly.
- R5: An entry with action 2'b11 (link) makes the next fetch at its bits 63:32. A link that also has the end bit set finishes the walk without fetching the target.
- R6: A transfer carrying the end bit finishes the walk on the clock edge that samples mv_done_i. done_o is then high for exactly one cycle with busy_o low.
- R7: A transfer with attribute bit 2 (interrupt) set raises irq_o for exactly one cycle. The pulse comes on the same edge that samples mv_done_i for it. No other entry raises irq_o.
- R8: An entry with the valid bit clear stops the walk with no command issued. It sets err_desc_o, sets err_state_o to 2'b01 and pulses done_o.
- R9: A transfer whose address or length has either of its two low bits set, or a link whose address does, is treated as in R8 before any command is issued.
- R10: With the reserved check enabled (the default), a nonzero bit 3 or any nonzero bit in 15:6 is treated as in R8.
- R11: At a clean finish, if the sum of the transfer lengths differs from the expected byte count captured at start, err_len_o is set and err_state_o becomes 2'b10. If the sum matches, both flags stay 0.
- R12: start_i is ignored while busy, and so are changes to base_addr_i and expect_bytes_i then. The error flags and code hold after done_o and are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (sampled when idle) |
| base_addr_i | input | ADDR_W | Address of the first descriptor |
| expect_bytes_i | input | CNT_W | Expected total of transfer lengths |
| rd_req_o | output | 1 | Descriptor fetch request |
| rd_addr_o | output | ADDR_W | Descriptor fetch address |
| rd_ready_i | input | 1 | Memory accepts the fetch request |
| rd_rvalid_i | input | 1 | Fetched descriptor is valid |
| rd_rdata_i | input | ADDR_W+LEN_W+16 | Fetched descriptor word |
| cmd_valid_o | output | 1 | Transfer command offered to the data mover |
| cmd_ready_i | input | 1 | Data mover accepts the command |
| cmd_addr_o | output | ADDR_W | Transfer start address |
| cmd_len_o | output | LEN_W+1 | Transfer length in bytes (1..65536) |
| mv_done_i | input | 1 | Data mover finished the accepted command |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle end-of-walk strobe |
| irq_o | output | 1 | One-cycle per-descriptor interrupt pulse |
| err_desc_o | output | 1 | Sticky malformed-descriptor flag |
| err_len_o | output | 1 | Sticky length-mismatch flag |
| err_state_o | output | 2 | 00 none, 01 descriptor error, 10 length mismatch |

## Verification
Every result is a registered output, so its due cycle is counted in clock edges from the edge that samples start_i. With the bench memory answering one cycle after a fetch and the mover raising mv_done_i two edges after accepting a command, a single terminal transfer puts the fetch out after edge 0. The command appears after edge 3, and done_o and irq_o both rise after edge 7. The timing test samples at the falling edge after every one of edges 1 to 7, so that it checks done_o is low up to edge 6 and high exactly after edge 7. The other scenarios wait for done_o at falling edges and then read the sticky flags. They read the irq count two cycles later, once the monitor has recorded the pulse.

// File: rtl/dcw_pkg.sv
`timescale 1ns/1ps
package dcw_pkg;

   localparam int ATTR_W = 16;

   // attribute bit positions; the action pair is decoded as {ACT2, ACT1}
   localparam int A_VLD     = 0;
   localparam int A_END     = 1;
   localparam int A_INT     = 2;
   localparam int A_ZERO    = 3;
   localparam int A_ACT1    = 4;
   localparam int A_ACT2    = 5;
   localparam int A_RSVD_LO = 6;

   typedef enum logic [1:0] {
      ACT_NOP  = 2'b00,
      ACT_RSVD = 2'b01,
      ACT_XFER = 2'b10,
      ACT_LINK = 2'b11
   } dcw_act_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_WAIT,
      S_DECODE,
      S_ISSUE,
      S_MOVE
   } dcw_state_e;

   typedef struct packed {
      logic     last;
      logic     intr;
      dcw_act_e act;
   } dcw_attr_t;

   localparam logic [1:0] ERRST_NONE = 2'b00;
   localparam logic [1:0] ERRST_DESC = 2'b01;
   localparam logic [1:0] ERRST_LEN  = 2'b10;

endpackage

// File: rtl/dcw_decode.sv
`timescale 1ns/1ps
module dcw_decode import dcw_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int ALIGN_LOG2 = 2,
   parameter bit CHECK_RSVD = 1'b1,
   localparam int DESC_W    = ADDR_W + LEN_W + ATTR_W
) (
   input  logic [DESC_W-1:0] desc_i,
   output dcw_attr_t         attr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LEN_W:0]    len_o,
   output logic              bad_o
);

   logic [ATTR_W-1:0] attr_f;
   logic [LEN_W-1:0]  len_f;
   logic              rsvd_bad;
   logic              addr_mis;
   logic              len_mis;
   logic              vld;

   assign attr_f = desc_i[ATTR_W-1:0];
   assign len_f  = desc_i[ATTR_W +: LEN_W];
   assign addr_o = desc_i[ATTR_W+LEN_W +: ADDR_W];
   assign vld    = attr_f[A_VLD];

   assign attr_o.last = attr_f[A_END];
   assign attr_o.intr = attr_f[A_INT];
   assign attr_o.act  = dcw_act_e'(attr_f[A_ACT2:A_ACT1]);

   // zero length field encodes the full 2**LEN_W bytes
   assign len_o = (len_f == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_f};

   generate
      if (CHECK_RSVD) begin : g_rsvd_chk
         assign rsvd_bad = attr_f[A_ZERO] | (|attr_f[ATTR_W-1:A_RSVD_LO]);
      end else begin : g_rsvd_off
         assign rsvd_bad = 1'b0;
      end

      if (ALIGN_LOG2 > 0) begin : g_align_chk
         assign addr_mis = |addr_o[ALIGN_LOG2-1:0];
         assign len_mis  = |len_f[ALIGN_LOG2-1:0];
      end else begin : g_align_off
         assign addr_mis = 1'b0;
         assign len_mis  = 1'b0;
      end
   endgenerate

   always_comb begin
      bad_o = ~vld | rsvd_bad;
      if (attr_o.act == ACT_XFER) bad_o = bad_o | addr_mis | len_mis;
      if (attr_o.act == ACT_LINK) bad_o = bad_o | addr_mis;
   end

endmodule

// File: rtl/dcw_len_acc.sv
`timescale 1ns/1ps
module dcw_len_acc #(
   parameter int CNT_W = 32,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] expect_i,
   input  logic             add_i,
   input  logic [LEN_W:0]   len_i,
   output logic             mismatch_o
);

   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] expect_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q  <= '0;
         expect_q <= '0;
      end else if (clr_i) begin
         total_q  <= '0;
         expect_q <= expect_i;
      end else if (add_i) begin
         total_q  <= total_q + CNT_W'(len_i);
      end
   end

   assign mismatch_o = (total_q != expect_q);

endmodule

// File: rtl/desc_chain_walker.sv
`timescale 1ns/1ps
module desc_chain_walker import dcw_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int CNT_W      = 32,
   parameter int ALIGN_LOG2 = 2,
   parameter bit CHECK_RSVD = 1'b1,
   localparam int DESC_W    = ADDR_W + LEN_W + ATTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  expect_bytes_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ready_i,
   input  logic              rd_rvalid_i,
   input  logic [DESC_W-1:0] rd_rdata_i,
   output logic              cmd_valid_o,
   input  logic              cmd_ready_i,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic [LEN_W:0]    cmd_len_o,
   input  logic              mv_done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              irq_o,
   output logic              err_desc_o,
   output logic              err_len_o,
   output logic [1:0]        err_state_o
);

   localparam int                STEP       = DESC_W / 8;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_LOG2) - 1);

   generate
      if ((DESC_W % 8) != 0) begin : g_bad_desc_w
         $error("descriptor width must be a whole number of bytes");
      end
      if (LEN_W <= ALIGN_LOG2) begin : g_bad_len_w
         $error("length field too narrow for the alignment");
      end
      if (CNT_W <= LEN_W) begin : g_bad_cnt_w
         $error("byte counter must be wider than one length field");
      end
   endgenerate

   dcw_state_e        state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [DESC_W-1:0] desc_q;
   logic              done_q, irq_q, errd_q, errl_q;
   logic [1:0]        errst_q;

   dcw_attr_t         d_attr;
   logic [ADDR_W-1:0] d_addr;
   logic [LEN_W:0]    d_len;
   logic              d_bad;
   logic              len_mis;
   logic              acc_clr, acc_add;
   logic [ADDR_W-1:0] seq_addr;

   dcw_decode #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .ALIGN_LOG2 (ALIGN_LOG2),
      .CHECK_RSVD (CHECK_RSVD)
   ) u_decode (
      .desc_i (desc_q),
      .attr_o (d_attr),
      .addr_o (d_addr),
      .len_o  (d_len),
      .bad_o  (d_bad)
   );

   assign acc_clr = (state_q == S_IDLE) && start_i;
   assign acc_add = (state_q == S_DECODE) && !d_bad && (d_attr.act == ACT_XFER);

   dcw_len_acc #(
      .CNT_W (CNT_W),
      .LEN_W (LEN_W)
   ) u_len_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (acc_clr),
      .expect_i   (expect_bytes_i),
      .add_i      (acc_add),
      .len_i      (d_len),
      .mismatch_o (len_mis)
   );

   assign seq_addr = cur_q + ADDR_W'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         desc_q  <= '0;
         done_q  <= 1'b0;
         irq_q   <= 1'b0;
         errd_q  <= 1'b0;
         errl_q  <= 1'b0;
         errst_q <= ERRST_NONE;
      end else begin
         done_q <= 1'b0;
         irq_q  <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (start_i) begin
                  cur_q   <= base_addr_i;
                  errd_q  <= 1'b0;
                  errl_q  <= 1'b0;
                  errst_q <= ERRST_NONE;
                  state_q <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (rd_ready_i) state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (rd_rvalid_i) begin
                  desc_q  <= rd_rdata_i;
                  state_q <= S_DECODE;
               end
            end
            S_DECODE: begin
               if (d_bad) begin
                  errd_q  <= 1'b1;
                  errst_q <= ERRST_DESC;
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else if (d_attr.act == ACT_XFER) begin
                  state_q <= S_ISSUE;
               end else if (d_attr.last) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
                  if (len_mis) begin
                     errl_q  <= 1'b1;
                     errst_q <= ERRST_LEN;
                  end
               end else begin
                  cur_q   <= (d_attr.act == ACT_LINK) ? d_addr : seq_addr;
                  state_q <= S_FETCH;
               end
            end
            S_ISSUE: begin
               if (cmd_ready_i) state_q <= S_MOVE;
            end
            S_MOVE: begin
               if (mv_done_i) begin
                  irq_q <= d_attr.intr;
                  if (d_attr.last) begin
                     done_q  <= 1'b1;
                     state_q <= S_IDLE;
                     if (len_mis) begin
                        errl_q  <= 1'b1;
                        errst_q <= ERRST_LEN;
                     end
                  end else begin
                     cur_q   <= seq_addr;
                     state_q <= S_FETCH;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign rd_req_o    = (state_q == S_FETCH);
   assign rd_addr_o   = cur_q;
   assign cmd_valid_o = (state_q == S_ISSUE);
   assign cmd_addr_o  = d_addr;
   assign cmd_len_o   = d_len;
   assign busy_o      = (state_q != S_IDLE);
   assign done_o      = done_q;
   assign irq_o       = irq_q;
   assign err_desc_o  = errd_q;
   assign err_len_o   = errl_q;
   assign err_state_o = errst_q;

   // ---------------- assertions ----------------
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !busy_o && !done_o && !irq_o && !err_desc_o && !err_len_o);

   assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ready_i |=> rd_req_o && $stable(rd_addr_o));

   assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o));

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_irq_after_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(mv_done_i));

   assert_cmd_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> ((cmd_addr_o & ALIGN_MASK) == '0) && (cmd_len_o[ALIGN_LOG2-1:0] == '0));

   assert_no_cmd_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_desc_o |-> !cmd_valid_o);

   assert_err_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_desc_o && err_len_o));

   assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(err_desc_o) && $stable(err_len_o) && $stable(err_state_o));

endmodule

// File: tb/desc_chain_walker_test.sv
`timescale 1ns/1ps
module desc_chain_walker_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [31:0] expect_b = '0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_ready;
   logic        rd_rvalid = 1'b0;
   logic [63:0] rd_rdata = '0;
   logic        cmd_valid;
   logic        cmd_ready = 1'b1;
   logic [31:0] cmd_addr;
   logic [16:0] cmd_len;
   logic        mv_done = 1'b0;
   logic        busy, done, irq, err_desc, err_len;
   logic [1:0]  err_state;

   assign rd_ready = 1'b1;

   desc_chain_walker uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
      .expect_bytes_i(expect_b), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
      .rd_ready_i(rd_ready), .rd_rvalid_i(rd_rvalid), .rd_rdata_i(rd_rdata),
      .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_addr_o(cmd_addr),
      .cmd_len_o(cmd_len), .mv_done_i(mv_done), .busy_o(busy), .done_o(done),
      .irq_o(irq), .err_desc_o(err_desc), .err_len_o(err_len), .err_state_o(err_state)
   );

   // ---------------- memory, mover and monitors ----------------
   logic [63:0] mem [64];
   logic        log_clr = 1'b0;
   logic [31:0] fetch_log [16];
   logic [31:0] cmd_alog [16];
   logic [31:0] cmd_llog [16];
   int          n_fetch = 0, n_cmd = 0, irq_cnt = 0, irq_ok = 0;
   int          mv_cnt = 0;
   logic        mvd_d = 1'b0;

   always @(posedge clk) begin
      rd_rvalid <= 1'b0;
      if (rd_req && rd_ready) begin
         rd_rvalid <= 1'b1;
         rd_rdata  <= mem[rd_addr[8:3]];
      end
      mv_done <= 1'b0;
      if (cmd_valid && cmd_ready) mv_cnt <= 2;
      else if (mv_cnt != 0) begin
         mv_cnt <= mv_cnt - 1;
         if (mv_cnt == 1) mv_done <= 1'b1;
      end
      mvd_d <= mv_done;
      if (log_clr) begin
         n_fetch <= 0; n_cmd <= 0; irq_cnt <= 0; irq_ok <= 0;
      end else begin
         if (rd_req && rd_ready && n_fetch < 16) begin
            fetch_log[n_fetch] <= rd_addr;
            n_fetch <= n_fetch + 1;
         end
         if (cmd_valid && cmd_ready && n_cmd < 16) begin
            cmd_alog[n_cmd] <= cmd_addr;
            cmd_llog[n_cmd] <= {15'b0, cmd_len};
            n_cmd <= n_cmd + 1;
         end
         if (irq) begin
            irq_cnt <= irq_cnt + 1;
            if (mvd_d) irq_ok <= irq_ok + 1;
         end
      end
   end

   // ---------------- checking helpers ----------------
   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic kick(input logic [31:0] b, input logic [31:0] e);
      @(negedge clk);
      log_clr = 1'b1;
      @(negedge clk);
      log_clr   = 1'b0;
      base_addr = b;
      expect_b  = e;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (done) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   // ---------------- vector table: one descriptor at 0x40 ----------------
   localparam int NROW = 12;
   localparam logic [63:0] T_DESC [NROW] = '{
      {32'h0000_1000, 16'h0100, 16'h0027},  // 0 R3 R6 R7 transfer, end, interrupt
      {32'h0000_2000, 16'h0000, 16'h0023},  // 1 R3 length field 0 = 65536
      {32'h0000_3000, 16'h0040, 16'h0022},  // 2 R8 valid clear
      {32'h0000_3002, 16'h0040, 16'h0023},  // 3 R9 misaligned address
      {32'h0000_3000, 16'h0042, 16'h0023},  // 4 R9 misaligned length
      {32'h0000_3000, 16'h0040, 16'h0063},  // 5 R10 reserved bit 6
      {32'h0000_0000, 16'h0000, 16'h0003},  // 6 R4 no-op end
      {32'h0000_0000, 16'h0000, 16'h0013},  // 7 R4 reserved action end
      {32'h0000_4000, 16'h0080, 16'h0023},  // 8 R11 length mismatch
      {32'h0000_0100, 16'h0000, 16'h0033},  // 9 R5 link with end: no target fetch
      {32'h0000_0102, 16'h0000, 16'h0031},  // 10 R9 misaligned link
      {32'h0000_3000, 16'h0040, 16'h002B}   // 11 R10 bit 3 set
   };
   localparam logic [31:0] T_EXP  [NROW] = '{32'h100, 32'h10000, 0, 0, 0, 0, 0, 0, 32'h100, 0, 0, 0};
   localparam logic [31:0] T_LEN  [NROW] = '{32'h100, 32'h10000, 0, 0, 0, 0, 0, 0, 32'h80, 0, 0, 0};
   localparam int          T_NCMD [NROW] = '{1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0};
   localparam int          T_EDSC [NROW] = '{0, 0, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1};
   localparam int          T_ELEN [NROW] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0};
   localparam int          T_IRQ  [NROW] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

   function automatic string row_tag(input int r);
      case (r)
         0:       return "R3/R6/R7 transfer+end+irq";
         1:       return "R3 zero length";
         2:       return "R8 invalid entry";
         3, 4:    return "R9 misaligned transfer";
         5, 11:   return "R10 reserved bits";
         6, 7:    return "R4 skipped action";
         8:       return "R11 length mismatch";
         9:       return "R5 terminal link";
         default: return "R9 misaligned link";
      endcase
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      bit seen;
      for (int i = 0; i < 64; i++) mem[i] = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !rd_req && !cmd_valid, "R1 idle in reset", {29'b0, busy, rd_req, cmd_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !irq, "R1 after reset", {29'b0, busy, done, irq}, 0);
      chk(!err_desc && !err_len && err_state == 2'b00, "R1 error flags", {28'b0, err_desc, err_len, err_state}, 0);

      // table walk
      for (int r = 0; r < NROW; r++) begin
         mem[8] = T_DESC[r];
         kick(32'h40, T_EXP[r]);
         wait_done(seen);
         chk(seen, {row_tag(r), " done seen"}, {31'b0, seen}, 1);
         chk(!busy, {row_tag(r), " idle at done"}, {31'b0, busy}, 0);
         chk(err_desc == T_EDSC[r][0], {row_tag(r), " err_desc"}, {31'b0, err_desc}, T_EDSC[r]);
         chk(err_len == T_ELEN[r][0], {row_tag(r), " err_len"}, {31'b0, err_len}, T_ELEN[r]);
         chk(err_state == (T_EDSC[r] != 0 ? 2'b01 : (T_ELEN[r] != 0 ? 2'b10 : 2'b00)),
             {row_tag(r), " err_state"}, {30'b0, err_state},
             (T_EDSC[r] != 0 ? 32'd1 : (T_ELEN[r] != 0 ? 32'd2 : 32'd0)));
         repeat (2) @(negedge clk);
         chk(n_cmd == T_NCMD[r], {row_tag(r), " command count"}, n_cmd, T_NCMD[r]);
         if (T_NCMD[r] != 0) begin
            chk(cmd_alog[0] == T_DESC[r][63:32], {row_tag(r), " command address"}, cmd_alog[0], T_DESC[r][63:32]);
            chk(cmd_llog[0] == T_LEN[r], {row_tag(r), " command length"}, cmd_llog[0], T_LEN[r]);
         end
         chk(irq_cnt == T_IRQ[r], {row_tag(r), " irq pulses"}, irq_cnt, T_IRQ[r]);
         chk(n_fetch == 1, {row_tag(r), " fetch count"}, n_fetch, 1);
         chk(fetch_log[0] == 32'h40, "R2 first fetch at base", fetch_log[0], 32'h40);
      end

      // R6 R7: cycle-exact latency of done and irq for a terminal transfer
      mem[8] = T_DESC[0];
      kick(32'h40, 32'h100);
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         chk(!done && !irq, "R6 done not early", {30'b0, done, irq}, 0);
      end
      @(negedge clk);
      chk(done, "R6 done after edge 7", {31'b0, done}, 1);
      chk(irq, "R7 irq with done", {31'b0, irq}, 1);
      @(negedge clk);
      chk(!done && !irq, "R6 R7 single-cycle pulses", {30'b0, done, irq}, 0);

      // R2 R4 R5 R7: multi-entry chain with no-op, link and reserved action
      mem[16] = {32'h0000_0000, 16'h0000, 16'h0001};
      mem[17] = {32'h0000_5000, 16'h0020, 16'h0025};
      mem[18] = {32'h0000_0100, 16'h0000, 16'h0031};
      mem[32] = {32'h0000_0000, 16'h0000, 16'h0011};
      mem[33] = {32'h0000_6000, 16'h0040, 16'h0023};
      kick(32'h80, 32'h60);
      wait_done(seen);
      repeat (2) @(negedge clk);
      chk(n_fetch == 5, "R2 R5 chain fetch count", n_fetch, 5);
      chk(fetch_log[1] == 32'h88, "R2 sequential step", fetch_log[1], 32'h88);
      chk(fetch_log[3] == 32'h100, "R5 link target", fetch_log[3], 32'h100);
      chk(fetch_log[4] == 32'h108, "R4 step past reserved action", fetch_log[4], 32'h108);
      chk(n_cmd == 2, "R4 only transfers issue", n_cmd, 2);
      chk(cmd_alog[1] == 32'h6000 && cmd_llog[1] == 32'h40, "R3 second command", cmd_alog[1], 32'h6000);
      chk(irq_cnt == 1, "R7 irq only for flagged entry", irq_cnt, 1);
      chk(irq_ok == 1, "R7 irq on mover completion edge", irq_ok, 1);
      chk(!err_desc && !err_len, "R11 matching sum", {30'b0, err_desc, err_len}, 0);

      // R3 R12: back-pressure holds the command, start while busy ignored
      cmd_ready = 1'b0;
      mem[8] = T_DESC[0];
      kick(32'h40, 32'h100);
      for (int i = 0; i < 20 && !cmd_valid; i++) @(negedge clk);
      base_addr = 32'h80;
      expect_b  = 32'h999;
      start     = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         start = 1'b0;
         chk(cmd_valid && cmd_addr == 32'h1000 && cmd_len == 17'h100, "R3 command held", cmd_addr, 32'h1000);
      end
      cmd_ready = 1'b1;
      wait_done(seen);
      repeat (2) @(negedge clk);
      chk(n_fetch == 1, "R12 busy start ignored", n_fetch, 1);
      chk(!err_len, "R12 expected count kept", {31'b0, err_len}, 0);

      // R12: flags hold after done, cleared by next start
      mem[8] = T_DESC[2];
      kick(32'h40, 0);
      wait_done(seen);
      repeat (5) @(negedge clk);
      chk(err_desc && err_state == 2'b01, "R12 flags hold", {30'b0, err_state}, 1);
      mem[8] = T_DESC[0];
      kick(32'h40, 32'h100);
      chk(!err_desc && err_state == 2'b00, "R12 flags cleared", {30'b0, err_state}, 0);
      wait_done(seen);
      repeat (2) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule